// File: doc/BRIEF.md
# Single-Cycle Register-Arithmetic Core

This block is a small processor core that runs one register-to-register arithmetic instruction on every clock. It holds its own instruction store and a 32-entry register file. On each rising edge the word at the program counter is decoded, two source registers are read, the ALU forms a sum, a difference or a bitwise OR, the result goes to the destination register, and the program counter moves on by four.

Programs and starting register values are placed through a load port. The port is accepted only while the core is held in reset. A combinational peek port reads any register, so results can be seen at the pins. Any word the core does not recognise raises an illegal flag for that cycle and changes no register.

Top module: `rtype_core`

## Requirements
- R1: An instruction word splits into op [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6] and func [5:0]. Only op = 0 can select an operation.
- R2: op 0 with func 0x21 writes rs + rt to rd, wrapping modulo 2^32 with no overflow indication.
- R3: op 0 with func 0x23 writes rs - rt to rd, wrapping modulo 2^32.
- R4: op 0 with func 0x25 writes the bitwise OR of rs and rt to rd.
- R5: pc_o is 0 in reset and rises by 4 on each clock after it. Its two low bits are always 0. The word fetched is pc_o[7:2], so the 64-word store wraps.
- R6: Any other op or func value writes no register and drives illegal_o high for the cycle that word is at the program counter.
- R7: Register 0 always reads as zero. Writes to it, from an instruction or from the load port, are discarded.
- R8: When load_en_i is high while rst_ni is low, a rising edge writes load_data_i. With load_sel_i = 0 the word goes to instruction word load_addr_i. With load_sel_i = 1 it goes to register load_addr_i[4:0]. With rst_ni high the port has no effect.
- R9: The shamt field has no effect on any of the three operations.
- R10: Exactly one instruction completes per clock. Its result is visible to the instruction in the next cycle.
- R11: peek_data_o shows register peek_addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; also opens the load port |
| load_en_i | input | 1 | Load strobe |
| load_sel_i | input | 1 | Load target: 0 instruction store, 1 register file |
| load_addr_i | input | 6 | Word index or register number |
| load_data_i | input | 32 | Load data |
| peek_addr_i | input | 5 | Register number to observe |
| peek_data_o | output | 32 | Contents of the observed register |
| pc_o | output | 32 | Program counter |
| illegal_o | output | 1 | Current word is not a supported instruction |

## Verification
The bench builds the core with its default 64-word instruction store. This lets a run reach the point where the program counter passes 256 and fetch wraps back to word 0 in a few dozen cycles. The bench preloads registers with values near the 32-bit limits, so wrapping add and subtract show up in plain results. Instructions that chain on earlier results, a write to register 0 and a load attempted outside reset are all observed through the peek port.

// File: rtl/rtype_pkg.sv
package rtype_pkg;
  localparam int XLEN = 32;
  localparam int NREGS = 32;
  localparam int RAW = $clog2(NREGS);

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] FN_ADD   = 6'h21;
  localparam logic [5:0] FN_SUB   = 6'h23;
  localparam logic [5:0] FN_OR    = 6'h25;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic [5:0]     op;
    logic [RAW-1:0] rs;
    logic [RAW-1:0] rt;
    logic [RAW-1:0] rd;
    logic [4:0]     shamt;
    logic [5:0]     func;
  } rinst_t;
endpackage

// File: rtl/rtype_imem.sv
module rtype_imem #(
  parameter int WORDS = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/rtype_regfile.sv
module rtype_regfile #(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  logic [DW-1:0] mem [NREGS];

  always_ff @(posedge clk_i) begin
    if (we_i && (waddr_i != '0)) mem[waddr_i] <= wdata_i;
  end

  // register 0 is hardwired to zero on every read port
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : mem[raddr_i[p]];
  end
endmodule

// File: rtl/rtype_decode.sv
module rtype_decode
  import rtype_pkg::*;
(
  input  logic [XLEN-1:0] inst_i,
  output logic [RAW-1:0]  rs_o,
  output logic [RAW-1:0]  rt_o,
  output logic [RAW-1:0]  rd_o,
  output alu_op_e         alu_op_o,
  output logic            legal_o
);
  rinst_t f;
  assign f    = rinst_t'(inst_i);
  assign rs_o = f.rs;
  assign rt_o = f.rt;
  assign rd_o = f.rd;

  always_comb begin
    alu_op_o = ALU_ADD;
    legal_o  = 1'b0;
    if (f.op == OP_REG) begin
      unique case (f.func)
        FN_ADD:  begin alu_op_o = ALU_ADD; legal_o = 1'b1; end
        FN_SUB:  begin alu_op_o = ALU_SUB; legal_o = 1'b1; end
        FN_OR:   begin alu_op_o = ALU_OR;  legal_o = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtype_alu.sv
module rtype_alu
  import rtype_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  logic [DW-1:0] sum;
  logic          sub;

  // one adder shared by add and subtract; carry-out dropped
  assign sub = (op_i == ALU_SUB);
  assign sum = a_i + (sub ? ~b_i : b_i) + {{(DW-1){1'b0}}, sub};

  always_comb begin
    case (op_i)
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = sum;
    endcase
  end
endmodule

// File: rtl/rtype_core.sv
module rtype_core
  import rtype_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  localparam int IMEM_AW   = $clog2(IMEM_WORDS),
  localparam int LD_AW     = (IMEM_AW > RAW) ? IMEM_AW : RAW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic             load_sel_i,
  input  logic [LD_AW-1:0] load_addr_i,
  input  logic [XLEN-1:0]  load_data_i,
  input  logic [RAW-1:0]   peek_addr_i,
  output logic [XLEN-1:0]  peek_data_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             illegal_o
);
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] inst;
  logic [RAW-1:0]  rs_addr, rt_addr, rd_addr;
  alu_op_e         alu_op;
  logic            legal;
  logic [XLEN-1:0] rs_data, rt_data, alu_res;
  logic            wr_en;
  logic            ld_imem, ld_reg;

  logic            rf_we;
  logic [RAW-1:0]  rf_waddr;
  logic [XLEN-1:0] rf_wdata;
  logic [2:0][RAW-1:0]  rf_raddr;
  logic [2:0][XLEN-1:0] rf_rdata;

  assign ld_imem = !rst_ni && load_en_i && !load_sel_i;
  assign ld_reg  = !rst_ni && load_en_i &&  load_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_q + XLEN'(4);
  end

  rtype_imem #(.WORDS(IMEM_WORDS), .DW(XLEN)) u_imem (
    .clk_i   (clk_i),
    .we_i    (ld_imem),
    .waddr_i (load_addr_i[IMEM_AW-1:0]),
    .wdata_i (load_data_i),
    .raddr_i (pc_q[IMEM_AW+1:2]),
    .rdata_o (inst)
  );

  rtype_decode u_dec (
    .inst_i   (inst),
    .rs_o     (rs_addr),
    .rt_o     (rt_addr),
    .rd_o     (rd_addr),
    .alu_op_o (alu_op),
    .legal_o  (legal)
  );

  assign rf_raddr = {peek_addr_i, rt_addr, rs_addr};
  assign rs_data  = rf_rdata[0];
  assign rt_data  = rf_rdata[1];
  assign peek_data_o = rf_rdata[2];

  rtype_alu #(.DW(XLEN)) u_alu (
    .op_i (alu_op),
    .a_i  (rs_data),
    .b_i  (rt_data),
    .y_o  (alu_res)
  );

  assign wr_en = rst_ni && legal;

  // reset owns the write port for loading; the datapath owns it otherwise
  assign rf_we    = rst_ni ? wr_en   : ld_reg;
  assign rf_waddr = rst_ni ? rd_addr : load_addr_i[RAW-1:0];
  assign rf_wdata = rst_ni ? alu_res : load_data_i;

  rtype_regfile #(.NREGS(NREGS), .DW(XLEN), .NRD(3)) u_rf (
    .clk_i   (clk_i),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  assign pc_o      = pc_q;
  assign illegal_o = rst_ni && !legal;
endmodule

// File: rtl/rtype_core_chk.sv
module rtype_core_chk
  import rtype_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_o,
  input logic            illegal_o,
  input logic            wr_en,
  input alu_op_e         alu_op,
  input logic [RAW-1:0]  rs_addr,
  input logic [XLEN-1:0] rs_data,
  input logic [XLEN-1:0] rt_data,
  input logic [XLEN-1:0] alu_res
);
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pc_o == $past(pc_o) + XLEN'(4)); // R5

  AST_PC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00); // R5

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_en); // R6

  AST_R0_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_addr == '0 |-> rs_data == '0); // R7

  AST_ADD_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && alu_op == ALU_ADD) |-> alu_res == rs_data + rt_data); // R2

  AST_SUB_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && alu_op == ALU_SUB) |-> alu_res == rs_data - rt_data); // R3
endmodule

bind rtype_core rtype_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pc_o      (pc_o),
  .illegal_o (illegal_o),
  .wr_en     (wr_en),
  .alu_op    (alu_op),
  .rs_addr   (rs_addr),
  .rs_data   (rs_data),
  .rt_data   (rt_data),
  .alu_res   (alu_res)
);

// File: tb/rtype_core_test.sv
module rtype_core_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_en_i = 1'b0;
  logic        load_sel_i = 1'b0;
  logic [5:0]  load_addr_i = '0;
  logic [31:0] load_data_i = '0;
  logic [4:0]  peek_addr_i = '0;
  logic [31:0] peek_data_o;
  logic [31:0] pc_o;
  logic        illegal_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  rtype_core uut (
    .clk_i, .rst_ni, .load_en_i, .load_sel_i, .load_addr_i, .load_data_i,
    .peek_addr_i, .peek_data_o, .pc_o, .illegal_o
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
      input logic [4:0] rt, input logic [4:0] rd, input logic [4:0] sh, input logic [5:0] fn);
    return {op, rs, rt, rd, sh, fn};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input bit sel, input int addr, input logic [31:0] d);
    @(negedge clk_i);
    load_en_i = 1'b1; load_sel_i = sel; load_addr_i = 6'(addr); load_data_i = d;
    @(negedge clk_i);
    load_en_i = 1'b0;
  endtask

  task automatic step_to(input int c);
    while (cyc < c) begin @(negedge clk_i); cyc++; end
  endtask

  task automatic peek(input string req, input int r, input logic [31:0] exp);
    @(negedge clk_i); cyc++;
    peek_addr_i = 5'(r);
    #1 check(req, peek_data_o, exp);
  endtask

  task automatic t_load_in_reset();
    for (int i = 0; i < 64; i++) load(0, i, 32'h0);
    for (int i = 0; i < 32; i++) load(1, i, 32'h0);
    load(1, 0, 32'hDEAD_BEEF);
    load(1, 1, 32'd5);
    load(1, 2, 32'd3);
    load(1, 3, 32'hFFFF_FFFF);
    load(1, 4, 32'h8000_0000);
    load(1, 10, 32'h0000_1234);
    load(1, 11, 32'h0000_ABCD);
    load(0, 0,  enc(6'h00, 5'd1, 5'd2, 5'd5, 5'd0, 6'h21));
    load(0, 1,  enc(6'h00, 5'd2, 5'd1, 5'd6, 5'd0, 6'h23));
    load(0, 2,  enc(6'h00, 5'd1, 5'd2, 5'd7, 5'd0, 6'h25));
    load(0, 3,  enc(6'h00, 5'd3, 5'd1, 5'd8, 5'd0, 6'h21));
    load(0, 4,  enc(6'h00, 5'd4, 5'd1, 5'd9, 5'd0, 6'h23));
    load(0, 5,  enc(6'h00, 5'd1, 5'd2, 5'd0, 5'd0, 6'h21));
    load(0, 6,  enc(6'h01, 5'd1, 5'd2, 5'd10, 5'd0, 6'h21));
    load(0, 7,  enc(6'h00, 5'd1, 5'd2, 5'd11, 5'd0, 6'h20));
    load(0, 8,  enc(6'h00, 5'd5, 5'd6, 5'd12, 5'd0, 6'h21));
    load(0, 9,  enc(6'h00, 5'd0, 5'd1, 5'd13, 5'd0, 6'h23));
    load(0, 10, enc(6'h00, 5'd1, 5'd2, 5'd14, 5'd7, 6'h21));
  endtask

  task automatic t_reset_state();
    #1;
    check("R5 pc in reset", pc_o, 32'h0);
    check("R6 no illegal in reset", {31'b0, illegal_o}, 32'h0);
  endtask

  task automatic t_run_and_ignore_load();
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc = 0;
    #1;
    check("R5 pc after release", pc_o, 32'h0);
    check("R6 legal word 0", {31'b0, illegal_o}, 32'h0);
    step_to(1);
    // R8: load attempts with reset released must be ignored
    load_en_i = 1'b1; load_sel_i = 1'b1; load_addr_i = 6'd1; load_data_i = 32'h0000_0999;
    @(negedge clk_i); cyc++;
    load_sel_i = 1'b0; load_addr_i = 6'd20;
    load_data_i = enc(6'h00, 5'd1, 5'd2, 5'd15, 5'd0, 6'h21);
    @(negedge clk_i); cyc++;
    load_en_i = 1'b0;
    #1 check("R5 pc steps by four", pc_o, 32'd12);
    step_to(6);
    #1 check("R6 bad opcode flagged", {31'b0, illegal_o}, 32'h1);
    check("R1 word index from pc", pc_o, 32'd24);
    step_to(7);
    #1 check("R6 bad func flagged", {31'b0, illegal_o}, 32'h1);
    step_to(8);
    #1 check("R6 add word legal", {31'b0, illegal_o}, 32'h0);
    step_to(20);
    #1 check("R8 imem load ignored out of reset", {31'b0, illegal_o}, 32'h1);
    check("R5 pc at word 20", pc_o, 32'd80);
  endtask

  task automatic t_results();
    peek("R2 add", 5, 32'd8);
    peek("R3 sub wraps", 6, 32'hFFFF_FFFE);
    peek("R4 or", 7, 32'd7);
    peek("R2 add wraps no overflow", 8, 32'd4);
    peek("R3 sub across sign", 9, 32'h7FFF_FFFB);
    peek("R7 r0 reads zero", 0, 32'h0);
    peek("R6 bad opcode no write", 10, 32'h0000_1234);
    peek("R6 bad func no write", 11, 32'h0000_ABCD);
    peek("R10 chained result", 12, 32'd6);
    peek("R7 r0 as source", 13, 32'hFFFF_FFFB);
    peek("R9 shamt ignored", 14, 32'd8);
    peek("R8 reg load ignored out of reset", 1, 32'd5);
    peek("R8 no stray write", 15, 32'h0);
    peek("R11 peek", 3, 32'hFFFF_FFFF);
  endtask

  task automatic t_wrap();
    step_to(64);
    #1 check("R5 pc past store end", pc_o, 32'd256);
    check("R5 fetch wraps to word 0", {31'b0, illegal_o}, 32'h0);
    step_to(70);
    #1 check("R5 wrapped word 6 flagged", {31'b0, illegal_o}, 32'h1);
  endtask

  initial begin
    t_load_in_reset();
    t_reset_state();
    t_run_and_ignore_load();
    t_results();
    t_wrap();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule